// File: doc/BRIEF.md
# MSI-X Interrupt Cause-to-Vector Router

This block collects interrupt events inside a device and turns them into message-vector requests. Events arrive on two 32-bit groups. The flow-handler group carries one bit per receive queue plus four DMA and error causes. The hardware-event group carries ten status causes. Each implemented bit is latched in a cause register, where software can see it and clear it. Each cause also has its own mask bit, and a mask bit of 1 silences that cause.

Every cause owns one steering byte. The low bits of the byte name the target vector. Bit 7 of the byte selects whether the cause stays latched after its vector fires. When at least one unmasked cause points at a vector, that vector becomes pending. A pending vector is issued only if its automask bit is clear. On issue, hardware sets that automask bit, so the vector cannot fire again until software writes 1 to the bit. Vector requests come out as single-cycle pulses, at most one per cycle, and only while the global routing enable is on.

Software reaches the block through a 32-bit register port. Reads are combinational. Writes take effect at the clock edge and honour byte enables, so single steering bytes can be written without touching their neighbours.

Top module: `msix_cause_router`

## Requirements
- R1: After reset, both cause registers, the automask register and the enable read 0, both mask registers read 0xFFFFFFFF, and no vector request is produced.
- R2: Only implemented cause bits latch. In the flow-handler group these are the receive queue bits 0 to NUM_RXQ-1 and bits 16, 17, 19 and 21. In the hardware group they are bits 0, 1, 6, 7, 8, 25, 26, 27, 29 and 30. All other bits read 0. The flow-handler causes sit at offset 0x800 and the hardware causes at 0x808.
- R3: Writing 1 to a cause bit clears it, and bits written as 0 are kept. If an event for that bit arrives in the same cycle as the clearing write, the bit stays set.
- R4: A mask bit of 1 at 0x804 (flow-handler) or 0x80C (hardware) blocks the matching cause from any vector, while the cause is still latched. A mask bit of 0 lets the cause through.
- R5: Receive queue q is steered by the byte at 0x880+q. Other flow-handler bit b is steered by the byte at 0x890+(b-16). Hardware bit b is steered by the byte at 0x890+0x10+b. The target vector is held in steering byte bits [3:0].
- R6: When an unmasked cause has been latched, the request for its vector appears one clock later. vec_req is high for one cycle and vec_num gives the vector number.
- R7: When a vector is issued, its bit in the automask register at 0x810 is set, and while that bit is set the vector is not issued again. Writing 1 to the bit clears it and re-arms the vector. If the hardware set and a software clear of the same bit fall in the same cycle, the set wins.
- R8: When several vectors are eligible, one vector is issued per cycle, starting with the lowest-numbered vector that is pending and not automasked.
- R9: When steering byte bit 7 is 0, the cause is cleared in the same cycle its vector is issued. When bit 7 is 1, the cause stays latched until software clears it.
- R10: Routing runs only while bit 25 of the control register at offset 0x000 is 1. While it is 0, causes still latch but no vector request is produced. Causes that are still latched fire once routing is enabled.
- R11: Each steering byte is written only when its byte enable is set. The other bytes of the same word keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Byte address of the register; bits [1:0] are ignored |
| reg_be | input | 4 | Byte enables for the write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| fh_event | input | 32 | Flow-handler cause events, one pulse per event |
| hw_event | input | 32 | Hardware cause events, one pulse per event |
| vec_req | output | 1 | Single-cycle vector request |
| vec_num | output | VEC_W | Number of the vector being requested |

## Verification
Two pairs of actions can land on the same clock edge. The first is a hardware event and a software write-1-clear of the same cause bit. The second is hardware setting an automask bit on issue while software writes 1 to clear that same bit. The bench forces each collision by driving the register write and the event, or the issue, into the same cycle. It then judges the result by reading back the cause register or the automask register, both of which must still show the bit set. Nested automask blocking, re-arming, and lowest-first arbitration are judged from the exact cycle and vector number of each vec_req pulse.

// File: rtl/msix_cause_router.sv
module msix_cause_router #(
  parameter int NUM_VEC = 16,
  parameter int NUM_RXQ = 16,
  localparam int VEC_W = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [11:0]       reg_addr,
  input  logic [3:0]        reg_be,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [31:0]       fh_event,
  input  logic [31:0]       hw_event,
  output logic              vec_req,
  output logic [VEC_W-1:0]  vec_num
);
  localparam int OTH_N = 48;
  localparam logic [31:0] RXQ_BITS = 32'((64'd1 << NUM_RXQ) - 64'd1);
  localparam logic [31:0] FH_VALID = RXQ_BITS | 32'h002B_0000;
  localparam logic [31:0] HW_VALID = 32'h6E00_01C3;
  localparam logic [9:0] WA_CTRL = 10'h000;
  localparam logic [9:0] WA_FHC  = 10'h200;
  localparam logic [9:0] WA_FHM  = 10'h201;
  localparam logic [9:0] WA_HWC  = 10'h202;
  localparam logic [9:0] WA_HWM  = 10'h203;
  localparam logic [9:0] WA_AM   = 10'h204;
  localparam int RX_WA0  = 'h220;
  localparam int OTH_WA0 = 'h224;

  logic               en_q;
  logic [31:0]        fh_cause_q, hw_cause_q, fh_mask_q, hw_mask_q;
  logic [NUM_VEC-1:0] amask_q;
  logic [7:0]         rx_tab  [NUM_RXQ];
  logic [7:0]         oth_tab [OTH_N];
  logic [7:0]         fh_ent  [32];
  logic [7:0]         hw_ent  [32];

  logic [9:0]         wa;
  logic [31:0]        bmask, wbits;
  logic [31:0]        fh_act, hw_act, fh_iss_clr, hw_iss_clr;
  logic [NUM_VEC-1:0] pend, elig, set_vec;
  logic [VEC_W-1:0]   pick;
  logic               issue;

  assign wa    = reg_addr[11:2];
  assign bmask = {{8{reg_be[3]}}, {8{reg_be[2]}}, {8{reg_be[1]}}, {8{reg_be[0]}}};
  assign wbits = reg_wdata & bmask;

  genvar b;
  generate
    for (b = 0; b < 32; b++) begin : g_ent
      if (FH_VALID[b] && b < 16) begin : g_fh_rx
        assign fh_ent[b] = rx_tab[b];
      end else if (FH_VALID[b]) begin : g_fh_oth
        assign fh_ent[b] = oth_tab[b-16];
      end else begin : g_fh_none
        assign fh_ent[b] = 8'h00;
      end
      if (HW_VALID[b]) begin : g_hw
        assign hw_ent[b] = oth_tab[16+b];
      end else begin : g_hw_none
        assign hw_ent[b] = 8'h00;
      end
    end
  endgenerate

  assign fh_act = fh_cause_q & ~fh_mask_q;
  assign hw_act = hw_cause_q & ~hw_mask_q;

  always_comb begin
    pend = '0;
    for (int i = 0; i < 32; i++) begin
      for (int v = 0; v < NUM_VEC; v++) begin
        if (fh_act[i] && fh_ent[i][VEC_W-1:0] == VEC_W'(v)) pend[v] = 1'b1;
        if (hw_act[i] && hw_ent[i][VEC_W-1:0] == VEC_W'(v)) pend[v] = 1'b1;
      end
    end
  end

  assign elig  = pend & ~amask_q & {NUM_VEC{en_q}};
  assign issue = |elig;

  always_comb begin
    pick = '0;
    for (int v = NUM_VEC - 1; v >= 0; v--)
      if (elig[v]) pick = VEC_W'(v);
  end

  always_comb begin
    set_vec = '0;
    if (issue) set_vec[pick] = 1'b1;
    for (int i = 0; i < 32; i++) begin
      fh_iss_clr[i] = issue && fh_act[i] && !fh_ent[i][7] && fh_ent[i][VEC_W-1:0] == pick;
      hw_iss_clr[i] = issue && hw_act[i] && !hw_ent[i][7] && hw_ent[i][VEC_W-1:0] == pick;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q       <= 1'b0;
      fh_cause_q <= '0;
      hw_cause_q <= '0;
      fh_mask_q  <= '1;
      hw_mask_q  <= '1;
      amask_q    <= '0;
      vec_req    <= 1'b0;
      vec_num    <= '0;
    end else begin
      if (reg_wr && wa == WA_CTRL && reg_be[3]) en_q <= reg_wdata[25];
      if (reg_wr && wa == WA_FHM) fh_mask_q <= (fh_mask_q & ~bmask) | wbits;
      if (reg_wr && wa == WA_HWM) hw_mask_q <= (hw_mask_q & ~bmask) | wbits;
      fh_cause_q <= ((fh_cause_q & ~((reg_wr && wa == WA_FHC) ? wbits : 32'h0) & ~fh_iss_clr)
                     | fh_event) & FH_VALID;
      hw_cause_q <= ((hw_cause_q & ~((reg_wr && wa == WA_HWC) ? wbits : 32'h0) & ~hw_iss_clr)
                     | hw_event) & HW_VALID;
      amask_q    <= (amask_q & ~((reg_wr && wa == WA_AM) ? wbits[NUM_VEC-1:0] : '0)) | set_vec;
      vec_req    <= issue;
      vec_num    <= pick;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_RXQ; i++) rx_tab[i] <= 8'h00;
      for (int i = 0; i < OTH_N; i++) oth_tab[i] <= 8'h00;
    end else if (reg_wr) begin
      for (int i = 0; i < NUM_RXQ; i++)
        if (wa == 10'(RX_WA0 + i / 4) && reg_be[i % 4]) rx_tab[i] <= reg_wdata[8*(i%4) +: 8];
      for (int i = 0; i < OTH_N; i++)
        if (wa == 10'(OTH_WA0 + i / 4) && reg_be[i % 4]) oth_tab[i] <= reg_wdata[8*(i%4) +: 8];
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (wa)
      WA_CTRL: reg_rdata[25] = en_q;
      WA_FHC:  reg_rdata = fh_cause_q;
      WA_FHM:  reg_rdata = fh_mask_q;
      WA_HWC:  reg_rdata = hw_cause_q;
      WA_HWM:  reg_rdata = hw_mask_q;
      WA_AM:   reg_rdata[NUM_VEC-1:0] = amask_q;
      default: ;
    endcase
    for (int i = 0; i < NUM_RXQ; i++)
      if (wa == 10'(RX_WA0 + i / 4)) reg_rdata[8*(i%4) +: 8] = rx_tab[i];
    for (int i = 0; i < OTH_N; i++)
      if (wa == 10'(OTH_WA0 + i / 4)) reg_rdata[8*(i%4) +: 8] = oth_tab[i];
  end
endmodule

// File: rtl/msix_cause_router_chk.sv
module msix_cause_router_chk #(
  parameter int NUM_VEC = 16,
  parameter int NUM_RXQ = 16,
  localparam int VEC_W = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               vec_req,
  input logic [VEC_W-1:0]   vec_num,
  input logic [NUM_VEC-1:0] amask,
  input logic               route_en,
  input logic [31:0]        fh_cause,
  input logic [31:0]        hw_cause
);
  localparam logic [31:0] FH_OK = 32'((64'd1 << NUM_RXQ) - 64'd1) | 32'h002B_0000;
  localparam logic [31:0] HW_OK = 32'h6E00_01C3;

  assert_legal_causes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((fh_cause & ~FH_OK) == 32'h0) && ((hw_cause & ~HW_OK) == 32'h0));

  assert_amask_on_issue_R7: assert property (@(posedge clk) disable iff (!rst_n)
    vec_req |-> amask[vec_num]);

  assert_armed_before_issue_R7: assert property (@(posedge clk) disable iff (!rst_n)
    vec_req |-> (($past(amask) & (NUM_VEC'(1) << vec_num)) == '0));

  assert_no_refire_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_req && $past(vec_req)) |-> (vec_num != $past(vec_num)));

  assert_enable_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    vec_req |-> $past(route_en));
endmodule

bind msix_cause_router msix_cause_router_chk #(.NUM_VEC(NUM_VEC), .NUM_RXQ(NUM_RXQ)) u_chk (
  .clk(clk), .rst_n(rst_n), .vec_req(vec_req), .vec_num(vec_num),
  .amask(amask_q), .route_en(en_q), .fh_cause(fh_cause_q), .hw_cause(hw_cause_q));

// File: tb/msix_cause_router_bench.sv
module msix_cause_router_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        reg_wr = 0;
  logic [11:0] reg_addr = '0;
  logic [3:0]  reg_be = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] fh_event = '0;
  logic [31:0] hw_event = '0;
  logic        vec_req;
  logic [3:0]  vec_num;
  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  msix_cause_router u_msix_cause_router (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_be(reg_be),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fh_event(fh_event), .hw_event(hw_event),
    .vec_req(vec_req), .vec_num(vec_num));

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d, logic [3:0] be = 4'hF);
    reg_wr = 1; reg_addr = a; reg_wdata = d; reg_be = be;
    tick();
    reg_wr = 0; reg_be = '0;
  endtask

  task automatic rd(string tag, logic [11:0] a, logic [31:0] exp);
    reg_addr = a; #0.5;
    check(tag, reg_rdata, exp);
  endtask

  task automatic pulse(logic [31:0] fh, logic [31:0] hw);
    fh_event = fh; hw_event = hw;
    tick();
    fh_event = '0; hw_event = '0;
  endtask

  task automatic t_reset();
    rd("R1 fh cause", 12'h800, 32'h0);
    rd("R1 fh mask", 12'h804, 32'hFFFF_FFFF);
    rd("R1 hw cause", 12'h808, 32'h0);
    rd("R1 hw mask", 12'h80C, 32'hFFFF_FFFF);
    rd("R1 automask", 12'h810, 32'h0);
    rd("R1 enable", 12'h000, 32'h0);
    check("R1 vec_req", 32'(vec_req), 32'h0);
  endtask

  task automatic t_latch();
    wr(12'h804, 32'h0); wr(12'h80C, 32'h0);
    pulse(32'hFFFF_FFFF, 32'hFFFF_FFFF);
    rd("R2 fh implemented bits", 12'h800, 32'h002B_FFFF);
    rd("R2 hw implemented bits", 12'h808, 32'h6E00_01C3);
    for (int k = 0; k < 3; k++) begin
      check("R10 no request while disabled", 32'(vec_req), 32'h0);
      tick();
    end
    wr(12'h800, 32'hFFFF_FFFF); wr(12'h808, 32'hFFFF_FFFF);
    rd("R3 fh cleared", 12'h800, 32'h0);
    rd("R3 hw cleared", 12'h808, 32'h0);
    wr(12'h804, 32'hFFFF_FFFF); wr(12'h80C, 32'hFFFF_FFFF);
  endtask

  task automatic t_w1c();
    pulse(32'h28, 32'h0);
    wr(12'h800, 32'h8);
    rd("R3 partial clear keeps bit 5", 12'h800, 32'h20);
    fh_event = 32'h20;
    wr(12'h800, 32'h20);
    fh_event = '0;
    rd("R3 event beats clear", 12'h800, 32'h20);
    wr(12'h800, 32'h20);
    rd("R3 clear after race", 12'h800, 32'h0);
  endtask

  task automatic t_mask();
    wr(12'h000, 32'h0200_0000);
    rd("R10 enable readback", 12'h000, 32'h0200_0000);
    wr(12'h8A4, 32'h8500_0000, 4'b1000);
    pulse(32'h0, 32'h80);
    rd("R4 masked cause latched", 12'h808, 32'h80);
    for (int k = 0; k < 3; k++) begin
      check("R4 masked cause silent", 32'(vec_req), 32'h0);
      tick();
    end
    wr(12'h80C, ~32'h80);
    check("R6 no request in unmask cycle", 32'(vec_req), 32'h0);
    tick();
    check("R6 request after unmask", 32'(vec_req), 32'h1);
    check("R5 hw bit7 vector", 32'(vec_num), 32'h5);
    rd("R9 non-auto-clear cause kept", 12'h808, 32'h80);
    tick();
    check("R7 automask blocks refire", 32'(vec_req), 32'h0);
    rd("R7 automask bit set", 12'h810, 32'h20);
    wr(12'h808, 32'h80);
    wr(12'h810, 32'h20);
    wr(12'h80C, 32'hFFFF_FFFF);
    tick();
    check("R7 no fire after cause cleared", 32'(vec_req), 32'h0);
  endtask

  task automatic t_rx_route();
    wr(12'h880, 32'h0B0A_0908);
    wr(12'h880, 32'h0007_0000, 4'b0100);
    rd("R11 byte write", 12'h880, 32'h0B07_0908);
    wr(12'h804, 32'hFFFF_FFFB);
    pulse(32'h4, 32'h0);
    check("R6 no request in latch cycle", 32'(vec_req), 32'h0);
    tick();
    check("R6 rx queue 2 request", 32'(vec_req), 32'h1);
    check("R5 rx queue 2 vector", 32'(vec_num), 32'h7);
    rd("R9 auto-clear cause cleared", 12'h800, 32'h0);
    tick();
    check("R6 single-cycle pulse", 32'(vec_req), 32'h0);
    rd("R7 automask vector 7", 12'h810, 32'h80);
    pulse(32'h4, 32'h0);
    tick();
    check("R7 blocked while automasked", 32'(vec_req), 32'h0);
    wr(12'h810, 32'h80);
    check("R7 not yet in clear cycle", 32'(vec_req), 32'h0);
    tick();
    check("R7 re-armed fires", 32'(vec_req), 32'h1);
    check("R7 re-armed vector", 32'(vec_num), 32'h7);
    tick();
    wr(12'h810, 32'hFFFF);
  endtask

  task automatic t_arb();
    wr(12'h880, 32'h0000_0409, 4'b0011);
    wr(12'h8A0, 32'h0000_000C, 4'b0001);
    wr(12'h804, 32'hFFFF_FFF8);
    wr(12'h80C, 32'hFFFF_FFFE);
    pulse(32'h3, 32'h1);
    tick();
    check("R8 first", 32'({vec_req, vec_num}), 32'h14);
    tick();
    check("R8 second", 32'({vec_req, vec_num}), 32'h19);
    tick();
    check("R8 third", 32'({vec_req, vec_num}), 32'h1C);
    tick();
    check("R8 done", 32'(vec_req), 32'h0);
    rd("R7 three automask bits", 12'h810, 32'h1210);
    rd("R9 fh auto-cleared", 12'h800, 32'h0);
    rd("R9 hw auto-cleared", 12'h808, 32'h0);
    wr(12'h810, 32'hFFFF);
  endtask

  task automatic t_amask_race();
    pulse(32'h2, 32'h0);
    wr(12'h810, 32'h10);
    check("R7 race request", 32'({vec_req, vec_num}), 32'h14);
    rd("R7 set beats clear", 12'h810, 32'h10);
    wr(12'h810, 32'hFFFF);
  endtask

  task automatic t_disable();
    wr(12'h000, 32'h0);
    pulse(32'h1, 32'h0);
    for (int k = 0; k < 3; k++) begin
      check("R10 disabled silent", 32'(vec_req), 32'h0);
      tick();
    end
    rd("R10 cause held while disabled", 12'h800, 32'h1);
    wr(12'h000, 32'h0200_0000);
    tick();
    check("R10 held cause fires on enable", 32'({vec_req, vec_num}), 32'h19);
  endtask

  initial begin
    #(4 * 50000);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    tick(); tick();
    rst_n = 1;
    tick();
    t_reset();
    t_latch();
    t_w1c();
    t_mask();
    t_rx_route();
    t_arb();
    t_amask_race();
    t_disable();
    tick();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule